// File: doc/BRIEF.md
# Vector-Extension Prefix Stream Decoder

This block sits in the front end of an instruction decoder that handles variable-length instructions. It takes instruction bytes one per clock over a valid/ready handshake. It recognises the two lead bytes that open a vector-extension prefix, C4h for the long (three-byte) form and C5h for the short (two-byte) form. It unpacks the payload bytes into one normalised record: opcode map, W, the R/X/B register extensions, the extra source register field, and the vector-length bit L. The short form carries no map, W, X or B fields, so the block fills in fixed defaults for them.

After the prefix the block takes the opcode byte and looks up the pair (map, opcode) in a small table that is set by parameters. Each entry states which vector lengths are legal and whether the extra register field must be unused. An encoding that breaks any of these rules raises an undefined-opcode fault. A lead byte that opens neither prefix form is passed through with a separate flag.

The record, the opcode, the fault bit and a one-cycle done pulse are presented together. While the done pulse is high the block refuses input.

Top module: `vxp_decoder`

## Requirements
- R1: A lead byte of C4h selects the long form: the done pulse follows the fourth accepted byte (lead, two payload bytes, opcode). C5h selects the short form: done follows the third accepted byte. Idle cycles between bytes do not change the result.
- R2: For the short form, out_map is 1 (0F map), out_w is 0, and out_x and out_b are 0.
- R3: The extension bits and register field are stored inverted in the stream and are output in true polarity. Long form, first payload byte: bit7 = not R, bit6 = not X, bit5 = not B, bits4:0 = map. Long form, second payload byte: bit7 = W, bits6:3 = not vreg, bit2 = L. Short form, payload byte: bit7 = not R, bits6:3 = not vreg, bit2 = L. Bits 1:0 of the last payload byte are ignored.
- R4: A table entry of class wide-only (form code 2) faults with L=0 and is accepted with L=1. A class either-length entry (code 0) is accepted with both values of L.
- R5: A table entry of class narrow-only (code 1) faults with L=1 and is accepted with L=0.
- R6: A table entry of class length-ignored (code 3) is accepted with either value of L.
- R7: A table entry flagged as having no extra register operand faults unless the raw field is 1111b (out_vreg = 0).
- R8: A long-form map value other than 1, 2 or 3 raises the fault.
- R9: Any other lead byte ends the instruction at once. The done pulse follows in the next cycle with out_nonvex=1, out_fault=0 and out_opcode equal to that byte.
- R10: out_done is high for exactly one cycle, and in_ready is low in that cycle. out_fault is only high together with out_done.
- R11: A (map, opcode) pair that matches no table entry raises the fault. When several entries match, the one at the lowest index decides.
- R12: While rst_n is low, in_ready, out_done and out_fault are 0. in_ready rises within three clocks of the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on in_byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte in this cycle |
| out_done | output | 1 | Result record valid (one cycle) |
| out_fault | output | 1 | Undefined-opcode fault |
| out_nonvex | output | 1 | Lead byte opened no prefix form |
| out_three | output | 1 | Long (three-byte) form was decoded |
| out_map | output | 5 | Opcode map select |
| out_w | output | 1 | W bit |
| out_r | output | 1 | R extension, true polarity |
| out_x | output | 1 | X extension, true polarity |
| out_b | output | 1 | B extension, true polarity |
| out_vreg | output | 4 | Extra register field, true polarity |
| out_l | output | 1 | Vector length (0 = 128-bit, 1 = 256-bit) |
| out_opcode | output | 8 | Opcode byte (or the passed-through lead byte) |

## Verification
A parser that ends in the wrong state shows up at once: the done pulse arrives one byte too early or too late, or in_ready stays low. A field latched from the wrong payload byte, or with the wrong polarity, shows up as a wrong record value in that same done cycle. A fault in the table lookup or in the length rules flips out_fault for the specific (map, opcode, L, vreg) pattern, again in the done cycle of that instruction. No stale state can hide across instructions, because each lead byte reloads every field of the record.

// File: rtl/vxp_pkg.sv
package vxp_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MAP_W  = 5;
  localparam int unsigned VREG_W = 4;

  localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
  localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;
  localparam logic [MAP_W-1:0]  MAP_DEFAULT = 5'd1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PAY1 = 3'd1,
    ST_PAY2 = 3'd2,
    ST_OPC  = 3'd3,
    ST_DONE = 3'd4
  } vxp_state_e;

  typedef enum logic [1:0] {
    FORM_EITHER = 2'd0,
    FORM_NARROW = 2'd1,
    FORM_WIDE   = 2'd2,
    FORM_LIG    = 2'd3
  } vxp_form_e;

  typedef struct packed {
    logic              three;
    logic              nonvex;
    logic [MAP_W-1:0]  map;
    logic              w;
    logic              r;
    logic              x;
    logic              b;
    logic [VREG_W-1:0] vreg;
    logic              l;
    logic [BYTE_W-1:0] opcode;
  } vxp_rec_t;

endpackage

// File: rtl/vxp_reset_sync.sv
module vxp_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vxp_fsm.sv
module vxp_fsm
  import vxp_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output vxp_rec_t          rec,
  output logic              done
);
  vxp_state_e st_q, st_d;
  vxp_rec_t   rec_q, rec_d;
  logic       done_q, done_d;
  logic       accept, is_long, is_short, rec_en;

  assign in_ready = srst_n && (st_q != ST_DONE);
  assign accept   = in_valid && in_ready;
  assign is_long  = (in_byte == LEAD_LONG);
  assign is_short = (in_byte == LEAD_SHORT);
  assign rec_en   = accept;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = (is_long || is_short) ? ST_PAY1 : ST_DONE;
      ST_PAY1: if (accept) st_d = rec_q.three ? ST_PAY2 : ST_OPC;
      ST_PAY2: if (accept) st_d = ST_OPC;
      ST_OPC:  if (accept) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // field capture
  always_comb begin
    rec_d = rec_q;
    unique case (st_q)
      ST_IDLE: begin
        rec_d        = '0;
        rec_d.map    = MAP_DEFAULT;
        rec_d.three  = is_long;
        rec_d.nonvex = !(is_long || is_short);
        if (!(is_long || is_short)) rec_d.opcode = in_byte;
      end
      ST_PAY1: begin
        rec_d.r = ~in_byte[7];
        if (rec_q.three) begin
          rec_d.x   = ~in_byte[6];
          rec_d.b   = ~in_byte[5];
          rec_d.map = in_byte[4:0];
        end else begin
          rec_d.vreg = ~in_byte[6:3];
          rec_d.l    = in_byte[2];
        end
      end
      ST_PAY2: begin
        rec_d.w    = in_byte[7];
        rec_d.vreg = ~in_byte[6:3];
        rec_d.l    = in_byte[2];
      end
      ST_OPC:  rec_d.opcode = in_byte;
      default: rec_d = rec_q;
    endcase
  end

  assign done_d = accept && ((st_q == ST_OPC) ||
                             ((st_q == ST_IDLE) && !(is_long || is_short)));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign rec  = rec_q;
  assign done = done_q;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);
  p_ready_low_done_r10: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> !in_ready);
  p_done_after_accept_r1: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> $past(accept));
  p_second_payload_long_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_PAY2) |-> rec_q.three);
endmodule

// File: rtl/vxp_form_table.sv
module vxp_form_table
  import vxp_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter logic [N_ENT*8-1:0] TBL_OPC   = '0,
  parameter logic [N_ENT*2-1:0] TBL_MAP   = '0,
  parameter logic [N_ENT*2-1:0] TBL_FORM  = '0,
  parameter logic [N_ENT-1:0]   TBL_NOVREG = '0
) (
  input  logic [MAP_W-1:0]  map,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              l,
  input  logic [VREG_W-1:0] vreg,
  output logic              fault
);
  localparam int unsigned KEY_PAD = MAP_W - 2;

  logic [N_ENT-1:0] hit;
  logic [N_ENT-1:0] viol;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    vxp_form_e form;
    logic      len_bad;
    assign form = vxp_form_e'(TBL_FORM[gi*2 +: 2]);
    assign hit[gi] = (opcode == TBL_OPC[gi*8 +: 8]) &&
                     (map == {{KEY_PAD{1'b0}}, TBL_MAP[gi*2 +: 2]});
    always_comb begin
      unique case (form)
        FORM_NARROW: len_bad = l;
        FORM_WIDE:   len_bad = !l;
        default:     len_bad = 1'b0;
      endcase
    end
    assign viol[gi] = len_bad || (TBL_NOVREG[gi] && (vreg != '0));
  end

  // lowest index wins; no match is a fault
  always_comb begin
    logic found;
    found = 1'b0;
    fault = 1'b1;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit[i] && !found) begin
        found = 1'b1;
        fault = viol[i];
      end
    end
  end
endmodule

// File: rtl/vxp_decoder.sv
module vxp_decoder
  import vxp_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter logic [N_ENT*8-1:0] TBL_OPC    = {8'h77, 8'h5A, 8'hEF, 8'h58},
  parameter logic [N_ENT*2-1:0] TBL_MAP    = {2'd1, 2'd2, 2'd1, 2'd1},
  parameter logic [N_ENT*2-1:0] TBL_FORM   = {2'd3, 2'd2, 2'd1, 2'd0},
  parameter logic [N_ENT-1:0]   TBL_NOVREG = 4'b1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       out_done,
  output logic       out_fault,
  output logic       out_nonvex,
  output logic       out_three,
  output logic [4:0] out_map,
  output logic       out_w,
  output logic       out_r,
  output logic       out_x,
  output logic       out_b,
  output logic [3:0] out_vreg,
  output logic       out_l,
  output logic [7:0] out_opcode
);
  logic     srst_n;
  vxp_rec_t rec;
  logic     done;
  logic     tbl_fault;
  logic     map_bad;

  vxp_reset_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  vxp_fsm u_fsm (
    .clk     (clk),
    .srst_n  (srst_n),
    .in_valid(in_valid),
    .in_byte (in_byte),
    .in_ready(in_ready),
    .rec     (rec),
    .done    (done)
  );

  vxp_form_table #(
    .N_ENT     (N_ENT),
    .TBL_OPC   (TBL_OPC),
    .TBL_MAP   (TBL_MAP),
    .TBL_FORM  (TBL_FORM),
    .TBL_NOVREG(TBL_NOVREG)
  ) u_tbl (
    .map   (rec.map),
    .opcode(rec.opcode),
    .l     (rec.l),
    .vreg  (rec.vreg),
    .fault (tbl_fault)
  );

  assign map_bad   = rec.three && !((rec.map == 5'd1) || (rec.map == 5'd2) || (rec.map == 5'd3));
  assign out_fault = done && !rec.nonvex && (map_bad || tbl_fault);

  assign out_done   = done;
  assign out_nonvex = rec.nonvex;
  assign out_three  = rec.three;
  assign out_map    = rec.map;
  assign out_w      = rec.w;
  assign out_r      = rec.r;
  assign out_x      = rec.x;
  assign out_b      = rec.b;
  assign out_vreg   = rec.vreg;
  assign out_l      = rec.l;
  assign out_opcode = rec.opcode;

  p_nonvex_clean_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (out_done && out_nonvex) |-> !out_fault);
  p_short_defaults_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (out_done && !out_nonvex && !out_three) |->
      (out_map == 5'd1) && !out_w && !out_x && !out_b);
  p_bad_map_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (out_done && out_three && (out_map == 5'd0)) |-> out_fault);
  p_fault_in_done_r10: assert property (@(posedge clk) disable iff (!srst_n)
    out_fault |-> out_done);
  p_reset_quiet_r12: assert property (@(posedge clk)
    !srst_n |-> (!in_ready && !out_done));
endmodule

// File: tb/vxp_decoder_bench.sv
`timescale 1ns/1ps
module vxp_decoder_bench;

  typedef struct packed {
    logic [23:0] tag;
    logic [2:0]  nb;
    logic [7:0]  b0, b1, b2, b3;
    logic        fault;
    logic [4:0]  map;
    logic        w, r, x, b;
    logic [3:0]  vreg;
    logic        l;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{"R2",  3'd3, 8'hC5, 8'hE8, 8'h58, 8'h00, 1'b0, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0},
    '{"R4",  3'd3, 8'hC5, 8'h7C, 8'h58, 8'h00, 1'b0, 5'd1, 1'b0,1'b1,1'b0,1'b0, 4'd0, 1'b1},
    '{"R5",  3'd3, 8'hC5, 8'hFC, 8'hEF, 8'h00, 1'b1, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b1},
    '{"R5",  3'd3, 8'hC5, 8'hF8, 8'hEF, 8'h00, 1'b0, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R3",  3'd4, 8'hC4, 8'hA2, 8'hD4, 8'h5A, 1'b0, 5'd2, 1'b1,1'b0,1'b1,1'b0, 4'd5, 1'b1},
    '{"R4",  3'd4, 8'hC4, 8'hA2, 8'hD0, 8'h5A, 1'b1, 5'd2, 1'b1,1'b0,1'b1,1'b0, 4'd5, 1'b0},
    '{"R6",  3'd3, 8'hC5, 8'hF8, 8'h77, 8'h00, 1'b0, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R6",  3'd3, 8'hC5, 8'hFC, 8'h77, 8'h00, 1'b0, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b1},
    '{"R7",  3'd3, 8'hC5, 8'hE8, 8'h77, 8'h00, 1'b1, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0},
    '{"R8",  3'd4, 8'hC4, 8'hE0, 8'h78, 8'h58, 1'b1, 5'd0, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R8",  3'd4, 8'hC4, 8'hE4, 8'h78, 8'h58, 1'b1, 5'd4, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R11", 3'd3, 8'hC5, 8'hF8, 8'h12, 8'h00, 1'b1, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R1",  3'd4, 8'hC4, 8'hE1, 8'h78, 8'h58, 1'b0, 5'd1, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R11", 3'd4, 8'hC4, 8'hE2, 8'h78, 8'h58, 1'b1, 5'd2, 1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0},
    '{"R3",  3'd4, 8'hC4, 8'h01, 8'h78, 8'h58, 1'b0, 5'd1, 1'b0,1'b1,1'b1,1'b1, 4'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, out_done, out_fault, out_nonvex, out_three;
  logic [4:0] out_map;
  logic       out_w, out_r, out_x, out_b, out_l;
  logic [3:0] out_vreg;
  logic [7:0] out_opcode;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vxp_decoder u_vxp_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_done(out_done), .out_fault(out_fault),
    .out_nonvex(out_nonvex), .out_three(out_three), .out_map(out_map),
    .out_w(out_w), .out_r(out_r), .out_x(out_x), .out_b(out_b),
    .out_vreg(out_vreg), .out_l(out_l), .out_opcode(out_opcode)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] v, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int gap);
    string t;
    logic [7:0] op;
    t  = $sformatf("%s", v.tag);
    op = (v.nb == 3'd4) ? v.b3 : v.b2;
    put(v.b0, gap);
    put(v.b1, gap);
    put(v.b2, gap);
    if (v.nb == 3'd4) put(v.b3, gap);
    @(negedge clk);
    chk(t, "done", out_done, 1'b1);
    chk(t, "fault", out_fault, v.fault);
    chk(t, "nonvex", out_nonvex, 1'b0);
    chk(t, "three", out_three, (v.b0 == 8'hC4));
    chk(t, "map", out_map, v.map);
    chk(t, "w/r/x/b", {v.w, v.r, v.x, v.b} ^ {out_w, out_r, out_x, out_b}, 4'h0);
    chk(t, "vreg", out_vreg, v.vreg);
    chk(t, "l", out_l, v.l);
    chk(t, "opcode", out_opcode, op);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12", "ready in reset", in_ready, 1'b0);
    chk("R12", "done in reset", out_done, 1'b0);
    chk("R12", "fault in reset", out_fault, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "ready after release", in_ready, 1'b1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 0);

    // R9 / R10: pass-through lead byte, pulse shape
    put(8'h90, 0);
    @(negedge clk);
    chk("R9", "done", out_done, 1'b1);
    chk("R9", "nonvex", out_nonvex, 1'b1);
    chk("R9", "fault", out_fault, 1'b0);
    chk("R9", "opcode", out_opcode, 8'h90);
    chk("R10", "ready in done", in_ready, 1'b0);
    @(negedge clk);
    chk("R10", "done one cycle", out_done, 1'b0);
    chk("R10", "ready back", in_ready, 1'b1);
    chk("R10", "fault without done", out_fault, 1'b0);

    // R1: long form needs four bytes, with gaps
    put(8'hC4, 2); put(8'hA2, 2); put(8'hD4, 2);
    @(negedge clk);
    chk("R1", "no early done", out_done, 1'b0);
    put(8'h5A, 2);
    @(negedge clk);
    chk("R1", "done after opcode", out_done, 1'b1);
    chk("R1", "fault gapped", out_fault, 1'b0);
    chk("R1", "vreg gapped", out_vreg, 4'd5);

    // R1: short form needs three bytes
    put(8'hC5, 0); put(8'hF8, 0);
    @(negedge clk);
    chk("R1", "short no early done", out_done, 1'b0);
    put(8'h58, 0);
    @(negedge clk);
    chk("R1", "short done", out_done, 1'b1);

    // R12: reset in the middle of a prefix
    put(8'hC4, 0); put(8'hE0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12", "ready mid reset", in_ready, 1'b0);
    rst_n = 1'b1;
    run_vec(VECS[0], 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule